// File: doc/BRIEF.md
# Control Register Upset Checker

This block holds a small bank of control registers that steer an external operation, together with a shadow copy of the values those registers should hold. Software-style writes arrive through a single write port that updates a live register and its shadow entry in the same cycle, so a legitimate write can never look like a corruption. When the client asks to start an operation, the block first walks the whole bank, comparing each live register with its shadow. Only after that walk does it release the operation. Once the operation reports completion, it walks the bank again.

Any difference found in either walk marks that particular operation as questionable. The block does not correct anything and does not reset anything; it only reports. The first failing index and the walk it was seen in (before or after) are latched until acknowledged, and a saturating counter records how many operations were questionable. A separate flip input lets a test environment toggle bits of one live register, modelling a particle-induced bit flip, without touching the shadow copy.

Top module: `ctrlreg_guard`

## Requirements
- R1: After reset every live register reads zero, the questionable flag, failing index and phase are zero, and the questionable counter is zero.
- R2: A write sets the addressed live register (visible on regsOut, register i at bits i*REG_W upward) and its shadow together, so an operation started after any sequence of writes is not marked questionable.
- R3: An opReq accepted while idle produces a one-cycle opGo pulse exactly NUM_REGS clock edges after the edge that sampled the request; opReq is ignored while an operation is in progress, giving exactly one opGo per accepted request.
- R4: A live register that differs from its shadow when an operation is requested raises suspect with failIdx equal to that register and failPhase 0 (before the operation).
- R5: A live register corrupted while the operation runs (between opGo and opDone) raises suspect with failIdx equal to that register and failPhase 1 (after the operation).
- R6: Within a walk the lowest differing index is reported, and once suspect is set the index and phase hold until acknowledged, whatever later walks find.
- R7: An ack pulse clears suspect, failIdx and failPhase.
- R8: Detection never changes a register: a corrupted live register keeps its flipped value until it is written again, and without a write or flip no live register changes.
- R9: suspectCnt rises by exactly one for each operation with a mismatch in either walk, even when both walks mismatch, and stays at all ones once it gets there.
- R10: A register corrupted during the before-walk, after its own index has already been compared, is caught by the after-walk with failPhase 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for live register and shadow |
| wrIdx | input | IDX_W | Register index to write |
| wrData | input | REG_W | Value to write |
| seuInj | input | 1 | Flip strobe: XOR seuMask into one live register only |
| seuIdx | input | IDX_W | Register index to flip |
| seuMask | input | REG_W | Bits to flip |
| opReq | input | 1 | Request to start an operation |
| opGo | output | 1 | One-cycle release of the operation after the before-walk |
| opDone | input | 1 | Operation completion pulse |
| ack | input | 1 | Clears the latched report |
| regsOut | output | NUM_REGS*REG_W | Live register contents driving the operation |
| suspect | output | 1 | Questionable-operation flag, sticky until ack |
| failIdx | output | IDX_W | First failing register index |
| failPhase | output | 1 | 0 = found before the operation, 1 = after |
| suspectCnt | output | CNT_W | Saturating count of questionable operations |

## Verification
A walk pointer that skipped or repeated an index would show as opGo arriving at the wrong edge and as a wrong or missing failIdx in the very operation that carried the flip. A shadow that drifted from the live bank would raise suspect on a clean operation right after a write, at the end of that operation's before-walk. A lost per-operation mismatch record would leave suspectCnt unchanged NUM_REGS edges after opDone, while a double count shows up as a step of two at the same point.

// File: rtl/ctrlreg_guard_pkg.sv
package ctrlreg_guard_pkg;

  typedef enum logic {
    PH_BEFORE = 1'b0,
    PH_AFTER  = 1'b1
  } walkPhase_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREWALK,
    ST_LAUNCH,
    ST_RUN,
    ST_POSTWALK
  } guardState_e;

  // Strobes from the sequencer to the register datapath
  typedef struct packed {
    logic       walkOn;   // compare the register at the walk pointer
    walkPhase_e phase;    // which walk is in progress
    logic       opStart;  // a new operation is accepted
    logic       opEnd;    // last compare of the after-walk
  } walkStrobe_t;

endpackage

// File: rtl/ctrlreg_guard_ctrl.sv
module ctrlreg_guard_ctrl
  import ctrlreg_guard_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opReq,
  input  logic             opDone,
  output logic             opGo,
  output logic [IDX_W-1:0] walkIdx,
  output walkStrobe_t      strobe
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  guardState_e state;
  logic        atLast;

  assign atLast = (walkIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      walkIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (opReq) begin
          state   <= ST_PREWALK;
          walkIdx <= '0;
        end
        ST_PREWALK: if (atLast) state <= ST_LAUNCH;
                    else walkIdx <= walkIdx + 1'b1;
        ST_LAUNCH:  state <= ST_RUN;
        ST_RUN: if (opDone) begin
          state   <= ST_POSTWALK;
          walkIdx <= '0;
        end
        ST_POSTWALK: if (atLast) state <= ST_IDLE;
                     else walkIdx <= walkIdx + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.walkOn  = (state == ST_PREWALK) || (state == ST_POSTWALK);
    strobe.phase   = (state == ST_POSTWALK) ? PH_AFTER : PH_BEFORE;
    strobe.opStart = (state == ST_IDLE) && opReq;
    strobe.opEnd   = (state == ST_POSTWALK) && atLast;
    opGo           = (state == ST_LAUNCH);
  end

  // R3: the release is a single-cycle pulse
  assert_go_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    opGo |=> !opGo);

  // R3: the walk pointer advances by one per cycle in ascending order
  assert_walk_ascend_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.walkOn && !atLast) |=> (walkIdx == $past(walkIdx) + 1'b1));

  // R3: the release always follows the final compare of the before-walk
  assert_go_after_walk_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.walkOn && strobe.phase == PH_BEFORE && atLast) |=> opGo);

endmodule

// File: rtl/ctrlreg_guard_dp.sv
module ctrlreg_guard_dp
  import ctrlreg_guard_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 16,
  parameter int CNT_W    = 4,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [IDX_W-1:0]          wrIdx,
  input  logic [REG_W-1:0]          wrData,
  input  logic                      seuInj,
  input  logic [IDX_W-1:0]          seuIdx,
  input  logic [REG_W-1:0]          seuMask,
  input  logic                      ack,
  input  logic [IDX_W-1:0]          walkIdx,
  input  walkStrobe_t               strobe,
  output logic [NUM_REGS*REG_W-1:0] regsOut,
  output logic                      suspect,
  output logic [IDX_W-1:0]          failIdx,
  output logic                      failPhase,
  output logic [CNT_W-1:0]          suspectCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [REG_W-1:0] liveReg   [NUM_REGS];
  logic [REG_W-1:0] shadowReg [NUM_REGS];
  logic             hit;
  logic             opBad;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gBank
    logic wrHere, flipHere;
    assign wrHere   = wrEn && (wrIdx == IDX_W'(g));
    assign flipHere = seuInj && (seuIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        liveReg[g]   <= '0;
        shadowReg[g] <= '0;
      end else if (wrHere) begin
        liveReg[g]   <= wrData;
        shadowReg[g] <= wrData;
      end else if (flipHere) begin
        liveReg[g]   <= liveReg[g] ^ seuMask;
      end
    end

    assign regsOut[g*REG_W +: REG_W] = liveReg[g];
  end

  assign hit = strobe.walkOn && (liveReg[walkIdx] != shadowReg[walkIdx]);

  // Latched report: the first mismatch since the last ack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suspect   <= 1'b0;
      failIdx   <= '0;
      failPhase <= 1'b0;
    end else if (hit && (!suspect || ack)) begin
      suspect   <= 1'b1;
      failIdx   <= walkIdx;
      failPhase <= strobe.phase;
    end else if (ack) begin
      suspect   <= 1'b0;
      failIdx   <= '0;
      failPhase <= 1'b0;
    end
  end

  // Per-operation verdict and saturating tally
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opBad      <= 1'b0;
      suspectCnt <= '0;
    end else begin
      if (strobe.opStart)  opBad <= 1'b0;
      else if (hit)        opBad <= 1'b1;
      if (strobe.opEnd && (opBad || hit) && suspectCnt != CNT_MAX)
        suspectCnt <= suspectCnt + 1'b1;
    end
  end

  // R9: the tally only ever steps by one
  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (suspectCnt != $past(suspectCnt)) |-> (suspectCnt == $past(suspectCnt) + 1'b1));

  // R9: a saturated tally stays saturated
  assert_cnt_sat_R9: assert property (@(posedge clk) disable iff (!rstN)
    (suspectCnt == CNT_MAX) |=> (suspectCnt == CNT_MAX));

  // R6: a latched report holds until acknowledged
  assert_report_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (suspect && !ack) |=> (suspect && $stable(failIdx) && $stable(failPhase)));

  // R7: an ack with no concurrent mismatch clears the report
  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !hit) |=> !suspect);

  // R8: the compare never alters the bank
  assert_no_correct_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !seuInj) |=> $stable(regsOut));

endmodule

// File: rtl/ctrlreg_guard.sv
module ctrlreg_guard
  import ctrlreg_guard_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 16,
  parameter int CNT_W    = 4,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [IDX_W-1:0]          wrIdx,
  input  logic [REG_W-1:0]          wrData,
  input  logic                      seuInj,
  input  logic [IDX_W-1:0]          seuIdx,
  input  logic [REG_W-1:0]          seuMask,
  input  logic                      opReq,
  output logic                      opGo,
  input  logic                      opDone,
  input  logic                      ack,
  output logic [NUM_REGS*REG_W-1:0] regsOut,
  output logic                      suspect,
  output logic [IDX_W-1:0]          failIdx,
  output logic                      failPhase,
  output logic [CNT_W-1:0]          suspectCnt
);

  walkStrobe_t      strobe;
  logic [IDX_W-1:0] walkIdx;

  ctrlreg_guard_ctrl #(.NUM_REGS(NUM_REGS)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .opReq   (opReq),
    .opDone  (opDone),
    .opGo    (opGo),
    .walkIdx (walkIdx),
    .strobe  (strobe)
  );

  ctrlreg_guard_dp #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .CNT_W(CNT_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .seuInj     (seuInj),
    .seuIdx     (seuIdx),
    .seuMask    (seuMask),
    .ack        (ack),
    .walkIdx    (walkIdx),
    .strobe     (strobe),
    .regsOut    (regsOut),
    .suspect    (suspect),
    .failIdx    (failIdx),
    .failPhase  (failPhase),
    .suspectCnt (suspectCnt)
  );

endmodule

// File: tb/ctrlreg_guard_test.sv
module ctrlreg_guard_test;

  localparam int NR    = 8;
  localparam int RW    = 16;
  localparam int CW    = 4;
  localparam int IW    = 3;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0, seuInj = 1'b0, opReq = 1'b0, opDone = 1'b0, ack = 1'b0;
  logic [IW-1:0] wrIdx = '0, seuIdx = '0;
  logic [RW-1:0] wrData = '0, seuMask = '0;
  logic          opGo, suspect, failPhase;
  logic [IW-1:0] failIdx;
  logic [CW-1:0] suspectCnt;
  logic [NR*RW-1:0] regsOut;

  int nChecks = 0, nFails = 0, goSeen = 0;
  bit finished = 0;

  logic [RW-1:0] refLive [NR];
  logic [RW-1:0] refShadow [NR];
  bit expSus = 0; int expIdx = 0; int expPh = 0; int expCnt = 0;

  ctrlreg_guard uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .seuInj(seuInj), .seuIdx(seuIdx), .seuMask(seuMask),
    .opReq(opReq), .opGo(opGo), .opDone(opDone), .ack(ack),
    .regsOut(regsOut), .suspect(suspect), .failIdx(failIdx),
    .failPhase(failPhase), .suspectCnt(suspectCnt)
  );

  always #10 clk = ~clk;
  always @(negedge clk) if (opGo === 1'b1) goSeen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int firstDiff();
    for (int i = 0; i < NR; i++) if (refLive[i] != refShadow[i]) return i;
    return -1;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic writeReg(input int idx, input logic [RW-1:0] val);
    wrEn = 1; wrIdx = IW'(idx); wrData = val;
    tick(); wrEn = 0;
    refLive[idx] = val; refShadow[idx] = val;
  endtask

  task automatic flipReg(input int idx, input logic [RW-1:0] mask);
    seuInj = 1; seuIdx = IW'(idx); seuMask = mask;
    tick(); seuInj = 0;
    refLive[idx] ^= mask;
  endtask

  task automatic doAck();
    ack = 1; tick(); ack = 0;
    expSus = 0; expIdx = 0; expPh = 0;
  endtask

  task automatic checkRegs(input string req);
    for (int i = 0; i < NR; i++) chk(req, 32'(regsOut[i*RW +: RW]), 32'(refLive[i]));
  endtask

  task automatic checkReport(input string req);
    chk({req, " suspect"}, 32'(suspect), 32'(expSus));
    chk({req, " failIdx"}, 32'(failIdx), 32'(expIdx));
    chk({req, " failPhase"}, 32'(failPhase), 32'(expPh));
    chk("R9 suspectCnt", 32'(suspectCnt), 32'(expCnt));
  endtask

  // mode 0: plain, 1: flip idx during before-walk after it is compared, 2: flip during run
  task automatic runOp(input int mode, input int idx, input logic [RW-1:0] mask);
    int cyc = 0; int fPre; int fPost; int goBefore;
    fPre = firstDiff(); goBefore = goSeen;
    opReq = 1; tick(); opReq = 0;
    while (opGo !== 1'b1 && cyc < 4 * NR) begin
      if (mode == 1 && cyc == 1) begin
        seuInj = 1; seuIdx = IW'(idx); seuMask = mask; refLive[idx] ^= mask;
      end
      tick(); seuInj = 0; cyc++;
    end
    chk("R3 opGo latency", 32'(cyc), 32'(NR));
    opReq = 1; tick(); opReq = 0;          // ignored while running (R3)
    if (mode == 2) flipReg(idx, mask);
    opDone = 1; tick(); opDone = 0;
    repeat (NR) tick();
    repeat (2) tick();
    chk("R3 single opGo", 32'(goSeen - goBefore), 32'd1);
    fPost = firstDiff();
    if (!expSus && fPre >= 0) begin expSus = 1; expIdx = fPre; expPh = 0; end
    else if (!expSus && fPost >= 0) begin expSus = 1; expIdx = fPost; expPh = 1; end
    if ((fPre >= 0 || fPost >= 0) && expCnt < CMAX) expCnt++;
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin refLive[i] = '0; refShadow[i] = '0; end
    void'($urandom(32'd2718));
    repeat (3) tick();
    // R1: reset state
    chk("R1 suspect", 32'(suspect), 0);
    chk("R1 suspectCnt", 32'(suspectCnt), 0);
    chk("R1 opGo", 32'(opGo), 0);
    checkRegs("R1 regsOut");
    rstN = 1; tick();

    // R2: random writes, then a clean operation
    for (int k = 0; k < 20; k++) writeReg(int'($urandom_range(NR - 1)), RW'($urandom));
    checkRegs("R2 regsOut");
    runOp(0, 0, '0);
    checkReport("R2 clean op");

    // R4 / R8: flip before the operation
    flipReg(5, 16'h0008);
    runOp(0, 0, '0);
    checkReport("R4 pre flip");
    checkRegs("R8 no correction");

    // R6 / R9: a second bad op, lower index, report holds, count rises
    flipReg(2, 16'h0100);
    runOp(0, 0, '0);
    checkReport("R6 hold");
    doAck();
    checkReport("R7 ack");
    runOp(0, 0, '0);
    checkReport("R6 lowest index");
    writeReg(2, refShadow[2]); writeReg(5, refShadow[5]); doAck();

    // R5: flip while the operation runs
    runOp(2, 6, 16'h8000);
    checkReport("R5 run flip");
    writeReg(6, refShadow[6]); doAck();

    // R10: flip index 0 after its before-walk compare
    runOp(1, 0, 16'h0001);
    checkReport("R10 late pre flip");
    writeReg(0, refShadow[0]); doAck();

    // Random mix
    for (int k = 0; k < 10; k++) begin
      int m; int ix;
      m = ($urandom_range(1) == 0) ? 0 : 2;
      ix = int'($urandom_range(NR - 1));
      if ($urandom_range(2) == 0) flipReg(int'($urandom_range(NR - 1)), RW'(1) << $urandom_range(RW - 1));
      runOp(m, ix, (m == 2) ? (RW'(1) << $urandom_range(RW - 1)) : '0);
      checkReport("R4 R5 random");
      checkRegs("R8 random");
      for (int i = 0; i < NR; i++) if (refLive[i] != refShadow[i] && $urandom_range(1) == 0) writeReg(i, refShadow[i]);
      if ($urandom_range(1) == 0) doAck();
    end

    // R9: saturation
    flipReg(3, 16'h0040);
    for (int k = 0; k < CMAX + 2; k++) runOp(0, 0, '0);
    chk("R9 saturated", 32'(suspectCnt), 32'(CMAX));
    checkReport("R9 final");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule